// File: doc/BRIEF.md
# Switchable Round-Robin / Ranked Bus Arbiter

This block decides which of several bus masters owns a shared bus. Each master raises a request line; the arbiter answers with a one-hot grant vector. Two scheduling policies are available and one configuration bit chooses between them at run time. In rotating mode the masters are served in turn. In ranked mode each master carries a 3-bit rank in the configuration word, and the highest-ranked requester wins.

The grant may change only at an arbitration point: a clock edge where the bus is idle (`bus_busy` low) or the current transfer finishes (`xfer_done` high). While a transfer runs, the owner keeps the bus whatever the request lines do. The grant is registered, so a decision made at one edge shows on `grant` after that edge. The control and status pins are plain levels with no handshake. The configuration word is written and read through a simple port. A write lands in the register at the next clock edge. It steers arbitration from the next arbitration point after that.

The `NUM_MASTERS` parameter sets the number of masters, either five or two. Rank fields exist only for the masters that are present.

Top module: `bus_arbiter`

## Requirements
- R1: After reset, `grant` is 1 (master 0) and `cfg_rd_data` reads 0x0000_0001 (rotating mode, all ranks 0).
- R2: Configuration bit 0 is the mode bit (1 = rotating, 0 = ranked). The rank of master i sits at bits [12+4i+2 : 12+4i]. All other bits read as 0 and ignore writes. With five masters, writing all ones reads back 0x7777_7001.
- R3: `grant` is one-hot on every cycle.
- R4: While `bus_busy` is 1 and `xfer_done` is 0, `grant` keeps its value, even if requests or the configuration change.
- R5: At an edge where `bus_busy` is 0 or `xfer_done` is 1, a new grant is decided, and it appears on `grant` after that edge.
- R6: At an arbitration point with no request, the grant goes to master 0.
- R7: In rotating mode the search starts at the master after the last master that was granted a request, and wraps past the top index. The rank fields have no effect. After reset the first master searched is master 0.
- R8: In ranked mode the requester with the largest rank value wins. Equal ranks go to the lower index, and 0 is the lowest rank.
- R9: A change of mode written during a transfer does not alter the grant until the next arbitration point. From that point the new mode applies.
- R10: At an arbitration point with at least one request, the new grant goes to a master that was requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_MASTERS | Request line of each master |
| bus_busy | input | 1 | A transfer is in progress |
| xfer_done | input | 1 | The current transfer finishes this cycle |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | Configuration word to write |
| cfg_rd_data | output | 32 | Current configuration word |
| grant | output | NUM_MASTERS | One-hot grant |

## Verification
The assertions check four properties on every cycle:
- the grant stays one-hot;
- the grant is frozen during a transfer;
- an arbitration point with requests gives the grant to a master that was requesting, and one without requests parks it on master 0;
- reserved configuration bits read zero.

Which requester should win is a question only the bench's scenarios can answer. The bench sweeps every request pattern in rotating mode and under several rank settings, including ties and zero ranks. It compares the results with an arithmetic model, and it also covers the timing of a mode change written during a transfer.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int CFG_W       = 32;
  localparam int MODE_BIT    = 0;
  localparam int RANK_W      = 3;
  localparam int RANK_LSB0   = 12;
  localparam int RANK_STRIDE = 4;

  // Bits of the configuration word that hold state for n masters.
  function automatic logic [CFG_W-1:0] cfg_mask(input int n);
    logic [CFG_W-1:0] m;
    m = '0;
    m[MODE_BIT] = 1'b1;
    for (int i = 0; i < n; i++) begin
      m = m | (CFG_W'((1 << RANK_W) - 1) << (RANK_LSB0 + RANK_STRIDE * i));
    end
    return m;
  endfunction
endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_q
);
  localparam logic [CFG_W-1:0] MASK      = cfg_mask(NUM_MASTERS);
  localparam logic [CFG_W-1:0] RESET_VAL = CFG_W'(1) << MODE_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= RESET_VAL;
    else if (wr_en) cfg_q <= wr_data & MASK;
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NUM_MASTERS = 5,
  localparam int IDX_W = $clog2(NUM_MASTERS)
) (
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [IDX_W-1:0]       last,
  output logic                   found,
  output logic [IDX_W-1:0]       idx
);
  int cand;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    cand  = 0;
    for (int off = 1; off <= NUM_MASTERS; off++) begin
      cand = (int'(last) + off) % NUM_MASTERS;
      if (!found && req[cand]) begin
        found = 1'b1;
        idx   = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/arb_rank_pick.sv
module arb_rank_pick
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 5,
  localparam int IDX_W = $clog2(NUM_MASTERS)
) (
  input  logic [NUM_MASTERS-1:0]        req,
  input  logic [NUM_MASTERS*RANK_W-1:0] ranks,
  output logic                          found,
  output logic [IDX_W-1:0]              idx
);
  logic [RANK_W-1:0] best;
  logic [RANK_W-1:0] r;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    r     = '0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      r = ranks[i*RANK_W +: RANK_W];
      // A strict comparison leaves ties with the lower index.
      if (req[i] && (!found || r > best)) begin
        found = 1'b1;
        best  = r;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   bus_busy,
  input  logic                   xfer_done,
  input  logic                   cfg_wr_en,
  input  logic [CFG_W-1:0]       cfg_wr_data,
  output logic [CFG_W-1:0]       cfg_rd_data,
  output logic [NUM_MASTERS-1:0] grant
);
  localparam int IDX_W = $clog2(NUM_MASTERS);
  localparam logic [NUM_MASTERS-1:0] PARK_GRANT = NUM_MASTERS'(1);
  localparam logic [CFG_W-1:0]       MASK       = cfg_mask(NUM_MASTERS);

  logic [CFG_W-1:0]              cfg_q;
  logic [NUM_MASTERS*RANK_W-1:0] ranks;
  logic                          rr_found, rk_found;
  logic [IDX_W-1:0]              rr_idx, rk_idx, next_idx, last_q;
  logic [NUM_MASTERS-1:0]        grant_q;
  logic                          arb_pt, rotating;

  arb_cfg_reg #(.NUM_MASTERS(NUM_MASTERS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .cfg_q(cfg_q)
  );

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_rank
    assign ranks[g*RANK_W +: RANK_W] = cfg_q[RANK_LSB0 + RANK_STRIDE*g +: RANK_W];
  end

  arb_rr_pick #(.NUM_MASTERS(NUM_MASTERS)) u_rr (
    .req(req), .last(last_q), .found(rr_found), .idx(rr_idx)
  );

  arb_rank_pick #(.NUM_MASTERS(NUM_MASTERS)) u_rank (
    .req(req), .ranks(ranks), .found(rk_found), .idx(rk_idx)
  );

  assign rotating = cfg_q[MODE_BIT];
  assign arb_pt   = !bus_busy || xfer_done;
  assign next_idx = rotating ? rr_idx : rk_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= PARK_GRANT;
      last_q  <= IDX_W'(NUM_MASTERS - 1);
    end else if (arb_pt) begin
      if (rotating ? rr_found : rk_found) begin
        grant_q <= NUM_MASTERS'(1) << next_idx;
        last_q  <= next_idx;
      end else begin
        grant_q <= PARK_GRANT;
      end
    end
  end

  assign grant       = grant_q;
  assign cfg_rd_data = cfg_q;

  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(grant));

  a_r4_hold_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !xfer_done) |=> $stable(grant));

  a_r10_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && (|req)) |=> ((grant & $past(req)) != '0));

  a_r6_park_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && !(|req)) |=> (grant == PARK_GRANT));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & ~MASK) == '0);
endmodule

// File: tb/bus_arbiter_bench.sv
`timescale 1ns/1ps
module bus_arbiter_bench;
  localparam int N = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          bus_busy = 1'b1;
  logic          xfer_done = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [31:0]   cfg_wr_data = '0;
  logic [31:0]   cfg_rd_data;
  logic [N-1:0]  grant;

  int checks = 0;
  int errors = 0;
  int last = N - 1;
  logic [31:0] cfg_model = 32'h1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_arbiter #(.NUM_MASTERS(N)) u_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_busy(bus_busy), .xfer_done(xfer_done),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data), .grant(grant)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int rank_of(input logic [31:0] c, input int i);
    return int'((c >> (12 + 4*i)) & 32'h7);
  endfunction

  // Expected winner, or -1 when nobody requests.
  function automatic int model_pick(input logic [N-1:0] r, input logic [31:0] c, input int lst);
    int best = -1;
    int bidx = -1;
    if (c[0]) begin
      for (int off = 1; off <= N; off++) begin
        int k = (lst + off) % N;
        if (bidx < 0 && r[k]) bidx = k;
      end
    end else begin
      for (int i = 0; i < N; i++)
        if (r[i] && rank_of(c, i) > best) begin best = rank_of(c, i); bidx = i; end
    end
    return bidx;
  endfunction

  // Write with the bus held busy, so that no arbitration takes place.
  task automatic write_cfg(input logic [31:0] v);
    bus_busy = 1'b1; xfer_done = 1'b0;
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    cyc();
    cfg_wr_en = 1'b0;
    cfg_model = v & 32'h7777_7001;
  endtask

  // One arbitration with the bus idle, checked against the model.
  task automatic arb_step(input logic [N-1:0] r, input string tag);
    int w;
    logic [N-1:0] e;
    bus_busy = 1'b0; xfer_done = 1'b0; req = r;
    w = model_pick(r, cfg_model, last);
    cyc();
    if (w < 0) e = N'(1);
    else begin e = N'(1) << w; last = w; end
    check(grant == e, tag, 32'(grant), 32'(e));
  endtask

  function automatic logic [31:0] rank_word(input int r0, r1, r2, r3, r4);
    return (32'(r0) << 12) | (32'(r1) << 16) | (32'(r2) << 20) | (32'(r3) << 24) | (32'(r4) << 28);
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] sets [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(grant == N'(1), "R1 grant", 32'(grant), 32'h1);
    check(cfg_rd_data == 32'h1, "R1 cfg", cfg_rd_data, 32'h1);

    // R2: register layout and reserved bits
    write_cfg(32'hFFFF_FFFF);
    check(cfg_rd_data == 32'h7777_7001, "R2 all ones", cfg_rd_data, 32'h7777_7001);
    write_cfg(32'h8888_8FFE);
    check(cfg_rd_data == 32'h0000_0000, "R2 reserved only", cfg_rd_data, 32'h0);
    write_cfg(32'h1);

    // R7/R10/R6: rotating sweep over every request pattern, twice
    for (int rep = 0; rep < 2; rep++)
      for (int p = 0; p < 32; p++) arb_step(N'(p), "R7 rotating sweep");
    // R7: ranks ignored in rotating mode
    write_cfg(32'h1 | rank_word(0, 0, 0, 0, 7));
    for (int p = 31; p >= 0; p--) arb_step(N'(p), "R7 ranks ignored");
    // R6: no requests parks on master 0
    arb_step('0, "R6 park");

    // R4/R5: hold during transfer
    arb_step(5'b00100, "R5 idle grant");
    bus_busy = 1'b1; xfer_done = 1'b0; req = 5'b11011;
    for (int k = 0; k < 3; k++) begin
      cyc();
      check(grant == 5'b00100, "R4 hold", 32'(grant), 32'h4);
    end
    xfer_done = 1'b1;
    cyc();
    check(grant == 5'b01000, "R5 done rotates", 32'(grant), 32'h8);
    last = 3;

    // R9: mode change during a transfer waits for the arbitration point
    req = 5'b11111;
    write_cfg(rank_word(7, 0, 0, 0, 0));
    cyc();
    check(grant == 5'b01000, "R9 held after write", 32'(grant), 32'h8);
    xfer_done = 1'b1;
    cyc();
    check(grant == 5'b00001, "R9 ranked applies", 32'(grant), 32'h1);
    last = 0;

    // R8: ranked sweeps with varied rank sets, ties and zeros
    sets[0] = rank_word(4, 3, 2, 1, 5);
    sets[1] = rank_word(0, 0, 0, 0, 0);
    sets[2] = rank_word(1, 5, 5, 2, 0);
    sets[3] = rank_word(7, 3, 7, 1, 6);
    for (int s = 0; s < 4; s++) begin
      write_cfg(sets[s]);
      for (int p = 0; p < 32; p++) arb_step(N'(p), "R8 ranked sweep");
    end
    // R9: back to rotating at run time
    write_cfg(32'h1);
    for (int p = 1; p < 32; p += 3) arb_step(N'(p), "R9 back to rotating");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule